// File: doc/BRIEF.md
# Selectable Serial Line Codec

This block turns a serial NRZ bit stream into one of five line codes: plain NRZ, NRZI, bi-phase space (FM0), bi-phase mark (FM1) and Manchester. A matching decoder recovers NRZ bits from a received line. A 3-bit code input selects the line code for both directions. Software must hold this code stable while the channel is idle. Timing comes from outside the block as two clock enables. `halfEn` pulses once per half-bit cell. `bitEn`, when it is high together with `halfEn`, marks the start of a bit cell.

The encoder drives its line from a register. The line changes only on the clock edge that follows an enable. The decoder samples the received line on the same enables. It does not recover a clock: the half-bit timing must already be aligned to the received cells. Protocol framing sits outside this block.

Top module: `serline_codec`

## Requirements
- R1: During and just after reset, `txLine` is 1 and `rxValid` is 0. `cfgErr` is 0 whenever `modeSel` is 000.
- R2: Code 000 (NRZ): on the edge where `halfEn` and `bitEn` are both high, `txLine` takes the value of `txData`. It holds that value for the whole bit. `txData` is ignored on all other cycles.
- R3: Code 010 (NRZI): at a bit start, `txLine` inverts when the data bit is 0 and keeps its level when the data bit is 1.
- R4: Code 100 (FM0): `txLine` inverts at every bit start. At mid-bit (`halfEn` high, `bitEn` low) it inverts again only when the bit is 0.
- R5: Code 101 (FM1): `txLine` inverts at every bit start. At mid-bit it inverts again only when the bit is 1.
- R6: Code 110 (Manchester): a 1 is sent high in the first half and low in the second. A 0 is sent low then high.
- R7: `txLine` changes only on the edge after a cycle in which `halfEn` is high, or when a reserved code is selected.
- R8: Codes 001, 011 and 111 are reserved. While one is selected, `cfgErr` is 1 in the same cycle, `txLine` is 1 from the next edge on, and `rxValid` stays 0.
- R9: `rxValid` is a single-cycle pulse. It appears on the cycle after a bit-start enable, and only if a mid-bit enable came since the previous bit start.
- R10: The decoder samples the first half of a bit at the mid-bit enable and the second half at the next bit-start enable. With `rxValid`, `rxData` gives the bit just ended:
  - NRZ and Manchester: the first-half level.
  - NRZI: 1 when the first-half level equals the level at the end of the previous bit.
  - FM0: 1 when the two halves are equal.
  - FM1: 1 when the two halves differ.
- R11: `bitEn` high while `halfEn` is low has no effect on `txLine`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Line code select |
| halfEn | input | 1 | Half-bit cell enable |
| bitEn | input | 1 | Bit start qualifier; valid together with `halfEn` |
| txData | input | 1 | NRZ data bit to send |
| txLine | output | 1 | Encoded line out |
| rxLine | input | 1 | Received line in |
| rxData | output | 1 | Decoded data bit |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| cfgErr | output | 1 | Reserved code selected |

## Verification
The assertions check the following on every cycle:
- the NRZ bit-start value;
- NRZI hold for a 1;
- the forced inversion at each FM bit start;
- the Manchester mid-bit inversion;
- line stability between enables;
- reserved-code idling and the error flag;
- the single-cycle shape of `rxValid`.

The data-dependent mid-bit choices of FM0 and FM1, NRZI inversion on zeros, and the decoded bit values depend on the history of several cells. Only the bench's loopback scenarios show these. In those scenarios a behavioural model predicts every `txLine` level and every decoded bit, over alternating, constant and pseudo-random data with noise and stray `bitEn` pulses between enables.

// File: rtl/serline_pkg.sv
package serline_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_NRZ  = 3'b000,
    CODE_NRZI = 3'b010,
    CODE_FM0  = 3'b100,
    CODE_FM1  = 3'b101,
    CODE_MAN  = 3'b110,
    CODE_BAD  = 3'b111
  } lineCode_e;

  typedef struct packed {
    logic      bndStb;   // bit start (halfEn and bitEn)
    logic      midStb;   // mid-bit (halfEn without bitEn)
    logic      decStb;   // complete cell captured, emit a decoded bit
    logic      idleStb;  // reserved code: force idle line
    lineCode_e code;
  } cellStrobe_t;
endpackage

// File: rtl/serline_ctrl.sv
module serline_ctrl
  import serline_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] modeSel,
  input  logic              halfEn,
  input  logic              bitEn,
  output cellStrobe_t       strb,
  output logic              cfgErr
);
  lineCode_e codeD;
  logic      midSeen;
  logic      bndNow;
  logic      midNow;

  always_comb begin
    case (modeSel)
      3'b000:  codeD = CODE_NRZ;
      3'b010:  codeD = CODE_NRZI;
      3'b100:  codeD = CODE_FM0;
      3'b101:  codeD = CODE_FM1;
      3'b110:  codeD = CODE_MAN;
      default: codeD = CODE_BAD;
    endcase
  end

  assign cfgErr = (codeD == CODE_BAD);
  assign bndNow = halfEn & bitEn;
  assign midNow = halfEn & ~bitEn;

  // Tracks whether the first half of the current cell has been sampled.
  always_ff @(posedge clk) begin
    if (!rstN)       midSeen <= 1'b0;
    else if (bndNow) midSeen <= 1'b0;
    else if (midNow) midSeen <= 1'b1;
  end

  always_comb begin
    strb.bndStb  = bndNow;
    strb.midStb  = midNow;
    strb.decStb  = bndNow & midSeen & ~cfgErr;
    strb.idleStb = cfgErr;
    strb.code    = codeD;
  end
endmodule

// File: rtl/serline_dp.sv
module serline_dp
  import serline_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cellStrobe_t strb,
  input  logic        txData,
  input  logic        rxLine,
  output logic        txLine,
  output logic        rxData,
  output logic        rxValid
);
  // ---------------- encoder ----------------
  logic lineQ;
  logic heldBit;
  logic nextLine;

  always_comb begin
    nextLine = lineQ;
    if (strb.idleStb) begin
      nextLine = 1'b1;
    end else if (strb.bndStb) begin
      case (strb.code)
        CODE_NRZ:          nextLine = txData;
        CODE_NRZI:         nextLine = txData ? lineQ : ~lineQ;
        CODE_FM0, CODE_FM1: nextLine = ~lineQ;
        CODE_MAN:          nextLine = txData;
        default:           nextLine = 1'b1;
      endcase
    end else if (strb.midStb) begin
      case (strb.code)
        CODE_FM0: nextLine = heldBit ? lineQ : ~lineQ;
        CODE_FM1: nextLine = heldBit ? ~lineQ : lineQ;
        CODE_MAN: nextLine = ~lineQ;
        default:  nextLine = lineQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ   <= 1'b1;
      heldBit <= 1'b0;
    end else begin
      lineQ <= nextLine;
      if (strb.bndStb) heldBit <= txData;
    end
  end

  assign txLine = lineQ;

  // ---------------- decoder ----------------
  logic firstHalf;
  logic endLevel;
  logic decBit;

  always_comb begin
    case (strb.code)
      CODE_NRZ:  decBit = firstHalf;
      CODE_NRZI: decBit = (firstHalf == endLevel);
      CODE_FM0:  decBit = (firstHalf == rxLine);
      CODE_FM1:  decBit = (firstHalf != rxLine);
      CODE_MAN:  decBit = firstHalf;
      default:   decBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstHalf <= 1'b1;
      endLevel  <= 1'b1;
      rxData    <= 1'b0;
      rxValid   <= 1'b0;
    end else begin
      if (strb.midStb) firstHalf <= rxLine;
      if (strb.bndStb) endLevel  <= rxLine;
      rxValid <= strb.decStb;
      if (strb.decStb) rxData <= decBit;
    end
  end
endmodule

// File: rtl/serline_codec.sv
module serline_codec
  import serline_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] modeSel,
  input  logic              halfEn,
  input  logic              bitEn,
  input  logic              txData,
  output logic              txLine,
  input  logic              rxLine,
  output logic              rxData,
  output logic              rxValid,
  output logic              cfgErr
);
  cellStrobe_t strb;

  serline_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .halfEn  (halfEn),
    .bitEn   (bitEn),
    .strb    (strb),
    .cfgErr  (cfgErr)
  );

  serline_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txData  (txData),
    .rxLine  (rxLine),
    .txLine  (txLine),
    .rxData  (rxData),
    .rxValid (rxValid)
  );
endmodule

// File: rtl/serline_chk.sv
module serline_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeSel,
  input logic       halfEn,
  input logic       bitEn,
  input logic       txData,
  input logic       txLine,
  input logic       rxValid,
  input logic       cfgErr
);
  logic resCode;
  assign resCode = modeSel inside {3'b001, 3'b011, 3'b111};

  assert_nrz_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'b000 && halfEn && bitEn) |=> (txLine == $past(txData)));

  assert_nrzi_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'b010 && halfEn && bitEn && txData) |=> $stable(txLine));

  assert_fm_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == 3'b100 || modeSel == 3'b101) && halfEn && bitEn) |=> (txLine != $past(txLine)));

  assert_man_mid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'b110 && halfEn && !bitEn) |=> (txLine != $past(txLine)));

  assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!halfEn && !resCode) |=> $stable(txLine));

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    resCode |=> txLine);

  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr == resCode);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_valid_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(halfEn && bitEn));
endmodule

bind serline_codec serline_chk chk_i (.*);

// File: tb/serline_codec_tb_top.sv
`timescale 1ns/1ps
module serline_codec_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic       halfEn = 1'b0;
  logic       bitEn = 1'b0;
  logic       txData = 1'b0;
  logic       rxLine;
  logic       txLine, rxData, rxValid, cfgErr;

  always #10 clk = ~clk;  // 50 MHz

  assign rxLine = txLine;  // loopback

  serline_codec dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .halfEn(halfEn), .bitEn(bitEn),
    .txData(txData), .txLine(txLine), .rxLine(rxLine), .rxData(rxData),
    .rxValid(rxValid), .cfgErr(cfgErr)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit mLine = 1'b1, mBit = 1'b0, mMid = 1'b0;
  bit eLine = 1'b1, eValid = 1'b0, eData = 1'b0;
  string lineTag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit isRes(logic [2:0] m);
    return !(m inside {3'b000, 3'b010, 3'b100, 3'b101, 3'b110});
  endfunction

  function automatic string modeTag(logic [2:0] m);
    case (m)
      3'b000:  return "R2";
      3'b010:  return "R3";
      3'b100:  return "R4";
      3'b101:  return "R5";
      3'b110:  return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit hE, bit bE, bit d);
    @(negedge clk);
    check1(lineTag, txLine, eLine);
    check1("R9", rxValid, eValid);
    if (eValid) check1("R10", rxData, eData);
    check1("R8", cfgErr, isRes(modeSel));
    halfEn = hE; bitEn = bE; txData = d;
    eValid = 1'b0;
    if (isRes(modeSel)) mLine = 1'b1;
    else if (hE && bE) begin
      case (modeSel)
        3'b000: mLine = d;
        3'b010: if (!d) mLine = !mLine;
        3'b100, 3'b101: mLine = !mLine;
        3'b110: mLine = d;
        default: ;
      endcase
    end else if (hE) begin
      case (modeSel)
        3'b100: if (!mBit) mLine = !mLine;
        3'b101: if (mBit) mLine = !mLine;
        3'b110: mLine = !mLine;
        default: ;
      endcase
    end
    if (hE && bE && mMid && !isRes(modeSel)) begin
      eValid = 1'b1;
      eData  = mBit;
    end
    if (hE && bE) begin mBit = d; mMid = 1'b0; end
    else if (hE) mMid = 1'b1;
    eLine = mLine;
    lineTag = hE ? modeTag(modeSel) : (bE ? "R11" : "R7");
  endtask

  task automatic doReset(logic [2:0] m);
    @(negedge clk);
    rstN = 1'b0; modeSel = m; halfEn = 1'b0; bitEn = 1'b0; txData = 1'b0;
    mLine = 1'b1; mBit = 1'b0; mMid = 1'b0;
    eLine = 1'b1; eValid = 1'b0; lineTag = "R1";
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check1("R1", txLine, 1'b1);
      check1("R1", rxValid, 1'b0);
      if (m == 3'b000) check1("R1", cfgErr, 1'b0);
    end
    rstN = 1'b1;
  endtask

  // one bit = two half cells of three cycles; noise on txData between bit starts
  task automatic runBits(int n, int pat);
    for (int b = 0; b < n; b++) begin
      bit d;
      case (pat)
        0: d = b[0];
        1: d = 1'b1;
        2: d = 1'b0;
        default: d = rnd();
      endcase
      step(1'b1, 1'b1, d);
      step(1'b0, (b % 3) == 0, rnd());  // stray bitEn: R11
      step(1'b0, 1'b0, rnd());
      step(1'b1, 1'b0, rnd());
      step(1'b0, 1'b0, rnd());
      step(1'b0, 1'b0, rnd());
    end
  endtask

  initial begin
    logic [2:0] goodModes [5] = '{3'b000, 3'b010, 3'b100, 3'b101, 3'b110};
    logic [2:0] badModes [3] = '{3'b001, 3'b011, 3'b111};
    doReset(3'b000);
    foreach (goodModes[i]) begin
      doReset(goodModes[i]);
      runBits(8, 0);
      runBits(6, 1);
      runBits(6, 2);
      runBits(16, 3);
      step(1'b0, 1'b0, 1'b0);
    end
    foreach (badModes[i]) begin
      doReset(badModes[i]);
      runBits(6, 3);
      step(1'b0, 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule